// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences one successive-approximation analog-to-digital converter. Software raises a start bit; the sequencer then waits out a start delay, fires a one-cycle sample-and-hold strobe, holds a conversion-active strobe for eleven ADC clock periods and, on the last of them, captures the converter's data word into a result register and raises a sticky completion flag. Every conversion is followed by a tracking phase, and no new sample-and-hold may happen before that phase ends.

The sequencer runs on the CPU clock. The slower ADC clock arrives as a one-cycle enable, `adc_tick_i`. The tracking length depends on a channel-type select and a programmable field `trk_cfg_i`. Single-ended channels also need an absolute minimum tracking time, which is counted in CPU cycles. The start delay is counted in CPU cycles for single-ended channels and in ADC ticks for differential channels. In free-running mode the start bit stays set and conversions follow back to back, each starting the moment the tracking phase before it ends.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, and while `enable_i` is low, `start_o`, `busy_o`, `tracking_o`, `sample_o`, `flag_o` and `result_o` are 0 (flag and result only from reset). While `enable_i` is low, the sequencer is held idle and `start_set_i` has no effect.
- R2: For single-ended channels (`diff` = 0), tracking lasts until `trk_cfg_i`+1 ADC ticks have been seen in it and until it has lasted at least MIN_CYC CPU cycles, where MIN_CYC = ceil(MIN_NS·CLK_MHZ/1000). It ends at whichever of the two is met later.
- R3: For differential channels (`diff` = 1), tracking lasts until 2·`trk_cfg_i`+3 ADC ticks have been seen, with no minimum time.
- R4: A start request accepted outside tracking reaches sample-and-hold after exactly 2 CPU cycles with the start bit set (single-ended), or after 2 ADC ticks (differential).
- R5: `sample_o` is high for exactly one cycle, which is the first cycle of `busy_o`. `busy_o` stays high until the 11th ADC tick seen from that cycle onward, inclusive.
- R6: On the cycle that ends a conversion, `result_o` takes the value of `conv_data_i` and `flag_o` is set on the same edge. This happens even if the flag is already set.
- R7: In single mode (`free_run_i` = 0), `start_o` clears on the same edge on which the conversion completes.
- R8: In free-running mode (`free_run_i` = 1), `start_o` stays set. Each following sample-and-hold comes in the cycle right after tracking ends, with no start delay. This gives a period of trk+12 ticks (single-ended) or 2·trk+14 ticks (differential).
- R9: A start request made during tracking sets `start_o` at once. Sample-and-hold is still deferred until tracking has run its full length, and the start delay of R4 follows the tracking.
- R10: Asserting `flag_clr_i` in a cycle without a completion clears `flag_o` on the next edge. If a completion falls in the same cycle, the completion wins.
- R11: Dropping `enable_i` aborts any tracking, delay or conversion, clears `start_o`, and leaves `flag_o` and `result_o` unchanged. Once enable returns, a full tracking phase runs before the first sample-and-hold.
- R12: The mode, channel type and tracking field are latched when enable rises and when a start request is accepted. Changes on those inputs afterwards do not affect the running delay, conversion or the tracking that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adc_tick_i | input | 1 | One-cycle ADC clock enable |
| enable_i | input | 1 | Converter enable |
| start_set_i | input | 1 | Software write of 1 to the start bit |
| free_run_i | input | 1 | 1 = free-running, 0 = single conversion |
| diff_i | input | 1 | 1 = differential channel, 0 = single-ended |
| trk_cfg_i | input | TW | Tracking-time field |
| flag_clr_i | input | 1 | Write-one-to-clear of the completion flag |
| conv_data_i | input | DW | Converter data word |
| start_o | output | 1 | Start bit state |
| tracking_o | output | 1 | Tracking phase active |
| sample_o | output | 1 | Sample-and-hold strobe |
| busy_o | output | 1 | Conversion active |
| flag_o | output | 1 | Conversion-complete flag |
| result_o | output | DW | Result register |

## Verification
A wrong phase counter shows up at the ports within one conversion. The tick count inside `busy_o`, the count in `tracking_o`, or the gap between a raised `start_o` and `sample_o` departs from its expected value as soon as that phase ends. A wrong latched setting or continuation bit shows up at the next completion, as a wrong `start_o` level, or at the next sample, as a start delay where none belongs. A lost abort shows within two cycles of enable dropping, as a strobe that stays high or a result that changes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_TRACK,
    ST_READY,
    ST_DELAY,
    ST_CONV
  } seq_state_e;

  localparam int unsigned CONV_TICKS = 11;
  localparam int unsigned START_STEPS = 2;
endpackage

// File: rtl/sar_step_cnt.sv
module sar_step_cnt #(
  parameter int unsigned LIMIT = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && step_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else if (step_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_trk_timer.sv
module sar_trk_timer #(
  parameter int unsigned TW      = 4,
  parameter int unsigned MIN_CYC = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          diff_i,
  input  logic [TW-1:0] trk_i,
  output logic          done_o
);
  localparam int unsigned CW = TW + 2;
  localparam int unsigned MW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] need, tcnt_q, tcnt_nxt;
  logic [MW-1:0] mcnt_q, mcnt_nxt;

  always_comb begin
    need     = diff_i ? (CW'({trk_i, 1'b0}) + CW'(3)) : (CW'(trk_i) + CW'(1));
    tcnt_nxt = (tick_i && tcnt_q != '1) ? tcnt_q + 1'b1 : tcnt_q;
    mcnt_nxt = (mcnt_q != MW'(MIN_CYC)) ? mcnt_q + 1'b1 : mcnt_q;
  end

  // tick and absolute-time conditions both cover the current cycle
  assign done_o = run_i && (tcnt_nxt >= need) && (diff_i || mcnt_nxt == MW'(MIN_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      mcnt_q <= '0;
    end else if (!run_i || done_o) begin
      tcnt_q <= '0;
      mcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_nxt;
      mcnt_q <= mcnt_nxt;
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          start_set_i,
  input  logic          free_run_i,
  input  logic          diff_i,
  input  logic [TW-1:0] trk_cfg_i,
  input  logic          trk_done_i,
  input  logic          dly_last_i,
  input  logic          conv_last_i,
  output logic          trk_run_o,
  output logic          dly_run_o,
  output logic          conv_run_o,
  output logic          complete_o,
  output logic          start_o,
  output logic          sample_o,
  output logic          diff_o,
  output logic [TW-1:0] trk_o
);
  seq_state_e    state_q, state_d;
  logic          start_q, cont_q, free_q, diff_q, sample_q, accept;
  logic [TW-1:0] trk_q;
  logic          req;

  assign req = start_q || start_set_i;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_OFF:   state_d = ST_TRACK;
      ST_TRACK: if (trk_done_i) begin
                  if (cont_q)   state_d = ST_CONV;
                  else if (req) begin state_d = ST_DELAY; accept = 1'b1; end
                  else          state_d = ST_READY;
                end
      ST_READY: if (req) begin state_d = ST_DELAY; accept = 1'b1; end
      ST_DELAY: if (dly_last_i)  state_d = ST_CONV;
      ST_CONV:  if (conv_last_i) state_d = ST_TRACK;
      default:  state_d = ST_OFF;
    endcase
    if (!enable_i) begin
      state_d = ST_OFF;
      accept  = 1'b0;
    end
  end

  assign complete_o = enable_i && state_q == ST_CONV && conv_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OFF;
      start_q  <= 1'b0;
      cont_q   <= 1'b0;
      free_q   <= 1'b0;
      diff_q   <= 1'b0;
      trk_q    <= '0;
      sample_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sample_q <= state_d == ST_CONV && state_q != ST_CONV;
      if (!enable_i)                  start_q <= 1'b0;
      else if (complete_o && !free_q) start_q <= 1'b0;
      else if (start_set_i)           start_q <= 1'b1;
      if (!enable_i)       cont_q <= 1'b0;
      else if (complete_o) cont_q <= free_q;
      if ((state_q == ST_OFF && enable_i) || accept) begin
        free_q <= free_run_i;
        diff_q <= diff_i;
        trk_q  <= trk_cfg_i;
      end
    end
  end

  assign trk_run_o  = state_q == ST_TRACK;
  assign dly_run_o  = state_q == ST_DELAY;
  assign conv_run_o = state_q == ST_CONV;
  assign start_o    = start_q;
  assign sample_o   = sample_q;
  assign diff_o     = diff_q;
  assign trk_o      = trk_q;

  // R1
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> state_q == ST_OFF && !start_q);
  // R5
  sample_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |=> !sample_q);
  // R5
  sample_in_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |-> state_q == ST_CONV);
  // R7
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o && !free_q |=> !start_q);
  // R8
  free_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o && free_q |=> start_q);
  // R9
  track_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && state_q == ST_TRACK && !trk_done_i |=> state_q == ST_TRACK);
  // R12
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY || state_q == ST_CONV) |=> $stable(free_q) && $stable(diff_q) && $stable(trk_q));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned DW      = 10,
  parameter int unsigned TW      = 4,
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned MIN_NS  = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adc_tick_i,
  input  logic          enable_i,
  input  logic          start_set_i,
  input  logic          free_run_i,
  input  logic          diff_i,
  input  logic [TW-1:0] trk_cfg_i,
  input  logic          flag_clr_i,
  input  logic [DW-1:0] conv_data_i,
  output logic          start_o,
  output logic          tracking_o,
  output logic          sample_o,
  output logic          busy_o,
  output logic          flag_o,
  output logic [DW-1:0] result_o
);
  localparam int unsigned MIN_CYC = (MIN_NS * CLK_MHZ + 999) / 1000;

  logic          trk_run, dly_run, conv_run, complete;
  logic          trk_done, dly_last, conv_last, diff_l;
  logic [TW-1:0] trk_l;
  logic          flag_q;
  logic [DW-1:0] result_q;

  sar_seq_ctrl #(.TW(TW)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .start_set_i, .free_run_i, .diff_i, .trk_cfg_i,
    .trk_done_i(trk_done), .dly_last_i(dly_last), .conv_last_i(conv_last),
    .trk_run_o(trk_run), .dly_run_o(dly_run), .conv_run_o(conv_run),
    .complete_o(complete), .start_o, .sample_o, .diff_o(diff_l), .trk_o(trk_l)
  );

  sar_trk_timer #(.TW(TW), .MIN_CYC(MIN_CYC)) u_trk (
    .clk_i, .rst_ni, .run_i(trk_run), .tick_i(adc_tick_i),
    .diff_i(diff_l), .trk_i(trk_l), .done_o(trk_done)
  );

  // start delay steps on CPU cycles (single-ended) or ADC ticks (differential)
  sar_step_cnt #(.LIMIT(START_STEPS)) u_dly (
    .clk_i, .rst_ni, .run_i(dly_run), .step_i(diff_l ? adc_tick_i : 1'b1), .last_o(dly_last)
  );

  sar_step_cnt #(.LIMIT(CONV_TICKS)) u_conv (
    .clk_i, .rst_ni, .run_i(conv_run), .step_i(adc_tick_i), .last_o(conv_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      result_q <= '0;
    end else if (complete) begin
      flag_q   <= 1'b1;
      result_q <= conv_data_i;
    end else if (flag_clr_i) begin
      flag_q   <= 1'b0;
    end
  end

  assign tracking_o = trk_run;
  assign busy_o     = conv_run;
  assign flag_o     = flag_q;
  assign result_o   = result_q;

  // R6
  complete_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete |=> flag_o && result_o == $past(conv_data_i));
  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !complete |=> !flag_o);
  // R11
  abort_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(result_o) && !busy_o && !tracking_o);
endmodule

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;
  localparam int DW = 10, TW = 4, DIV = 8, MIN_CYC = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, adc_tick = 1'b0, enable = 1'b0, start_set = 1'b0;
  logic free_run = 1'b0, diff = 1'b0, flag_clr = 1'b0;
  logic [TW-1:0] trk_cfg = '0;
  logic [DW-1:0] conv_data = '0;
  logic start_o, tracking_o, sample_o, busy_o, flag_o;
  logic [DW-1:0] result_o;

  sar_conv_seq #(.DW(DW), .TW(TW), .CLK_MHZ(200), .MIN_NS(500)) dut (
    .clk_i(clk), .rst_ni(rst_n), .adc_tick_i(adc_tick), .enable_i(enable),
    .start_set_i(start_set), .free_run_i(free_run), .diff_i(diff), .trk_cfg_i(trk_cfg),
    .flag_clr_i(flag_clr), .conv_data_i(conv_data), .start_o, .tracking_o,
    .sample_o, .busy_o, .flag_o, .result_o
  );

  typedef struct {
    int trk_mode;  // 0: tick count, 1: cycle count
    int trk_val;
    int wait_mode; // 0: none, 1: 2 cycles, 2: 2 ticks
    int res;
    int start_after;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_fail = 0, n_done = 0, exp_idx = 0;
  int div_cnt = 0, trk_cyc = 0, trk_tk = 0, wt_cyc = 0, wt_tk = 0, cv_tk = 0;
  bit trk_prev = 0, busy_prev = 0, have_cur = 0, aborting = 0, ended = 0;
  int cur_diff = 0, cur_trk = 0;

  function automatic int data_of(int k);
    return (k * 37 + 100) % 1024;
  endfunction

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // tracking expected for the settings in force during it
  function automatic exp_t trk_exp(int d, int t);
    exp_t e;
    int n;
    e = '{default: 0};
    if (d != 0) begin e.trk_mode = 0; e.trk_val = 2 * t + 3; end
    else begin
      n = t + 1;
      if ((n - 1) * DIV + 1 >= MIN_CYC) begin e.trk_mode = 0; e.trk_val = n; end
      else begin e.trk_mode = 1; e.trk_val = MIN_CYC; end
    end
    return e;
  endfunction

  // monitor and ADC tick source
  always @(negedge clk) begin
    div_cnt = (div_cnt + 1) % DIV;
    adc_tick = (div_cnt == 0);
    conv_data = DW'(data_of(n_done));
    if (rst_n) begin
      if (tracking_o) begin
        if (!trk_prev) begin trk_cyc = 0; trk_tk = 0; end
        trk_cyc++;
        trk_tk += int'(adc_tick);
        wt_cyc = 0; wt_tk = 0;
      end else if (start_o && !busy_o) begin
        wt_cyc++;
        wt_tk += int'(adc_tick);
      end
      if (sample_o) begin
        if (q.size() == 0) check("R5 unexpected sample", 1, 0);
        else begin
          cur = q.pop_front();
          have_cur = 1;
          if (cur.trk_mode == 0) check("R2/R3 tracking ticks", trk_tk, cur.trk_val);
          else                   check("R2 tracking min cycles", trk_cyc, cur.trk_val);
          case (cur.wait_mode)
            0: check("R8 no start delay", wt_cyc, 0);
            1: check("R4 start delay cycles", wt_cyc, 2);
            default: check("R4 start delay ticks", wt_tk, 2);
          endcase
        end
        wt_cyc = 0; wt_tk = 0; cv_tk = 0;
      end
      if (busy_o) cv_tk += int'(adc_tick);
      if (busy_prev && !busy_o && have_cur && !aborting) begin
        check("R5 conversion ticks", cv_tk, 11);
        check("R6 flag at completion", int'(flag_o), 1);
        check("R6 result loaded", int'(result_o), cur.res);
        check("R7/R8 start bit after completion", int'(start_o), cur.start_after);
        n_done++;
        conv_data = DW'(data_of(n_done));
        have_cur = 0;
      end
      trk_prev = tracking_o;
      busy_prev = busy_o;
    end
  end

  task automatic wait_ready();
    while (tracking_o || busy_o || start_o) @(negedge clk);
  endtask

  task automatic enable_seq(int d, int t);
    enable = 1'b0;
    diff = d[0]; trk_cfg = TW'(t); free_run = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    cur_diff = d; cur_trk = t;
    @(negedge clk);
  endtask

  task automatic push_item(int d, int wmode, int sa, int ed, int et);
    exp_t e;
    e = trk_exp(ed, et);
    e.wait_mode = wmode;
    e.res = data_of(exp_idx);
    e.start_after = sa;
    q.push_back(e);
    exp_idx++;
    if (d < 0) exp_idx--;
  endtask

  task automatic pulse_start(int d, int t, int fr);
    diff = d[0]; trk_cfg = TW'(t); free_run = fr[0];
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
  endtask

  task automatic do_single(int d, int t, bit scramble, bit early);
    if (!early) wait_ready();
    push_item(d, (d != 0) ? 2 : 1, 0, cur_diff, cur_trk);
    cur_diff = d; cur_trk = t;
    pulse_start(d, t, 0);
    if (early) check("R9 start set during tracking", int'(start_o && tracking_o), 1);
    if (scramble) begin
      free_run = 1'b1; diff = 1'b1; trk_cfg = '0;
    end
    while (start_o) @(negedge clk);
  endtask

  task automatic do_free(int d, int t, int k);
    int falls;
    bit prev;
    wait_ready();
    push_item(d, (d != 0) ? 2 : 1, 1, cur_diff, cur_trk);
    for (int i = 1; i < k; i++) push_item(d, 0, 1, d, t);
    cur_diff = d; cur_trk = t;
    pulse_start(d, t, 1);
    falls = 0; prev = busy_o;
    while (falls < k) begin
      @(negedge clk);
      if (prev && !busy_o) falls++;
      prev = busy_o;
    end
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] res_before;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 reset start_o", int'(start_o), 0);
    check("R1 reset flag_o", int'(flag_o), 0);
    check("R1 reset busy/tracking/sample", int'(busy_o | tracking_o | sample_o), 0);
    check("R1 reset result_o", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    @(negedge clk);
    check("R1 start ignored while disabled", int'(start_o | busy_o | tracking_o), 0);

    enable_seq(0, 2);
    check("R11 tracking after enable", int'(tracking_o), 1);
    do_single(0, 2, 0, 0);
    @(negedge clk);
    check("R6 flag stays set", int'(flag_o), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R10 flag cleared", int'(flag_o), 0);

    do_single(0, 15, 0, 0);
    do_single(1, 1, 0, 0);
    do_single(1, 0, 0, 0);
    do_single(0, 2, 0, 1);   // R9 request during tracking
    do_single(0, 15, 1, 0);  // R12 inputs scrambled after acceptance
    do_single(0, 2, 0, 0);   // tracking proves latched settings (R12)

    do_free(0, 15, 3);       // R8
    enable_seq(1, 0);
    do_free(1, 0, 3);        // R8 differential

    // R11 abort mid-conversion
    enable_seq(0, 15);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
    res_before = result_o;
    wait_ready();
    push_item(-1, 1, 0, cur_diff, cur_trk);
    pulse_start(0, 2, 0);
    while (!busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    aborting = 1;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 abort clears strobes", int'(busy_o | tracking_o | start_o), 0);
    check("R11 abort keeps flag", int'(flag_o), 0);
    check("R11 abort keeps result", int'(result_o), int'(res_before));
    enable = 1'b1;
    cur_diff = 0; cur_trk = 2;
    repeat (2) @(negedge clk);
    aborting = 0;
    check("R11 full tracking after re-enable", int'(tracking_o), 1);
    do_single(0, 2, 0, 0);

    repeat (20) @(negedge clk);
    check("R5 all expected conversions seen", q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule